// File: doc/BRIEF.md
# IrDA SIR Pulse Decoder

This block rebuilds a UART receive stream from the narrow optical pulses of a serial infrared link. The receive input `ir_rx_n` idles high. A pulse is a short low excursion on it. The block does not sample levels. It treats the falling edge of each pulse as the start of a zero bit. It then holds its serial output `rx_out` low for one full bit time, which is `BIT_CYCLES` cycles of the 16x baud clock. When no pulses arrive, `rx_out` stays high, which is a mark.

A pulse can be 3/16 of a bit wide. In the fixed-width mode it is about 1.63 µs wide, and at low baud rates that is shorter than one clock period. For this reason the edge is caught asynchronously in a set/reset flag. The flag is then brought into the clock domain through a synchroniser chain, and a one-cycle pulse event is taken from the end of that chain. When pulses arrive back to back, each new event restarts the count, so successive zeros merge into one continuous low level. A power-down input silences the decoder. A low on `rst_n` returns it to idle.

The output is a plain serial level that feeds a UART receiver. It has no valid/ready handshake, and no back-pressure is possible: every detected pulse must be stretched at once.

Top module: `sir_pulse_decoder`

## Requirements
- R1: While `rst_n` is low, `rx_out` is high. After `rst_n` is released with no pulses arriving, `rx_out` stays high.
- R2: Each falling edge on `ir_rx_n` (low means pulse present) produces exactly `BIT_CYCLES` (16) consecutive clock cycles of `rx_out` low, as one low run.
- R3: The first low cycle of `rx_out` follows the third rising clock edge after the falling edge of the pulse, whatever the phase of that edge within the clock period.
- R4: Pulses of any width are decoded the same way. This includes pulses narrower than one clock period and pulses several cycles wide.
- R5: A falling edge that arrives S cycles after the previous one, with 7 <= S <= 16, restarts the count. For n such pulses, the result is one continuous low run of 16 + S*(n-1) cycles.
- R6: Edges spaced more than 16 cycles apart produce n separate low runs of 16 cycles each. Each pair of runs is separated by S-16 high cycles.
- R7: From the first rising clock edge after `pwr_dn` goes high, `rx_out` is high, and any stretch in progress is abandoned. Pulses that arrive while `pwr_dn` is high produce no low, either during power-down or after its release. Decoding works normally again once `pwr_dn` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16x baud clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | High disables decoding and forces the output high |
| ir_rx_n | input | 1 | Infrared receive line; idles high, pulses are low |
| rx_out | output | 1 | Stretched serial receive line to the UART; idles high |

## Verification
Take the rising edge just before a pulse's falling edge as edge 0. The first low sample of `rx_out` is due at the falling clock edge that follows rising edge 3, and the low run lasts 16 cycles per isolated pulse. The effect of `pwr_dn` or `rst_n` is due at the next sample. The bench starts every stimulus from a known rising edge and places the pulse edges at fixed sub-cycle offsets. It samples `rx_out` only on falling clock edges and counts, per train, the index of the first low sample, the total number of low samples and the number of low runs. It compares these with values computed from the pulse offset, width, spacing and count.

// File: rtl/sirdec_pkg.sv
package sirdec_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_STRETCH = 1'b1
  } stretch_state_e;
endpackage

// File: rtl/sir_edge_capture.sv
// Asynchronous set/reset flag: set by the falling edge of the IR line,
// cleared by reset, power-down or the synchroniser acknowledge.
module sir_edge_capture (
  input  logic ir_rx_n,
  input  logic clr,
  output logic flag
);
  always_ff @(negedge ir_rx_n or posedge clr) begin
    if (clr) flag <= 1'b0;
    else     flag <= 1'b1;
  end
endmodule

// File: rtl/sir_pulse_sync.sv
// Synchroniser chain plus edge stage; yields a one-cycle pulse event.
module sir_pulse_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic flag,
  output logic ack,
  output logic pulse_evt
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sq[0] <= 1'b0;
    else if (pwr_dn) sq[0] <= 1'b0;
    else             sq[0] <= flag;
  end

  for (genvar i = 1; i < CHAIN; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sq[i] <= 1'b0;
      else if (pwr_dn) sq[i] <= 1'b0;
      else             sq[i] <= sq[i-1];
    end
  end

  assign ack       = sq[SYNC_STAGES-1];
  assign pulse_evt = sq[SYNC_STAGES-1] & ~sq[SYNC_STAGES];

  // R2
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |=> !pulse_evt);
endmodule

// File: rtl/sir_bit_stretch.sv
// Stretches each pulse event into BIT_CYCLES cycles of low output.
module sir_bit_stretch
  import sirdec_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic pulse_evt,
  output logic rx_low
);
  localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BIT_CYCLES - 1);

  stretch_state_e   state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (pwr_dn) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (pulse_evt) begin
      state <= ST_STRETCH;
      cnt   <= LOAD;
    end else if (state == ST_STRETCH) begin
      if (cnt == '0) state <= ST_IDLE;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign rx_low = (state == ST_STRETCH);

  // R2
  stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_low) |-> $past(pulse_evt));
  // R2
  stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_low) && !$past(pwr_dn)) |-> ($past(cnt) == '0));
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_evt && !pwr_dn) |=> (rx_low && cnt == LOAD));
endmodule

// File: rtl/sir_pulse_decoder.sv
module sir_pulse_decoder #(
  parameter int BIT_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic ir_rx_n,
  output logic rx_out
);
  logic flag, ack, pulse_evt, rx_low, clr;

  assign clr = ~rst_n | pwr_dn | ack;

  sir_edge_capture u_cap (
    .ir_rx_n (ir_rx_n),
    .clr     (clr),
    .flag    (flag)
  );

  sir_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .flag      (flag),
    .ack       (ack),
    .pulse_evt (pulse_evt)
  );

  sir_bit_stretch #(.BIT_CYCLES(BIT_CYCLES)) u_str (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .pulse_evt (pulse_evt),
    .rx_low    (rx_low)
  );

  assign rx_out = ~rx_low;

  // R7
  pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_dn) |-> rx_out);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> rx_out);
endmodule

// File: tb/tb_sir_pulse_decoder.sv
`timescale 1ns/1ps
module tb_sir_pulse_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn = 1'b0;
  logic ir_rx_n = 1'b1;
  logic rx_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sir_pulse_decoder dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ir_rx_n(ir_rx_n), .rx_out(rx_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse train from a rising edge: n pulses, spacing sp cycles.
  task automatic run_train(input real off, input real wid, input int sp, input int n,
                           input int window, output int first, output int lows, output int runs);
    int f = -1, l = 0, r = 0;
    logic prev = 1'b1;
    @(posedge clk);
    fork
      begin
        #(off);
        for (int i = 0; i < n; i++) begin
          ir_rx_n = 1'b0;
          #(wid);
          ir_rx_n = 1'b1;
          if (i < n - 1) #(4.0 * sp - wid);
        end
      end
      begin
        for (int k = 1; k <= window; k++) begin
          @(negedge clk);
          if (!rx_out) begin
            l++;
            if (f < 0) f = k;
            if (prev) r++;
          end
          prev = rx_out;
        end
      end
    join
    first = f; lows = l; runs = r;
  endtask

  task automatic count_lows(input int cyc, output int lows);
    int l = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (!rx_out) l++;
    end
    lows = l;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f, l, r;
    real offs [5] = '{0.5, 1.0, 2.5, 3.0, 3.5};
    real wids [4] = '{0.6, 4.0, 12.0, 40.0};
    int  sps  [6] = '{7, 10, 13, 16, 17, 24};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rx_out in reset", rx_out, 1);
    rst_n = 1'b1;
    count_lows(20, l);
    chk("R1 idle after reset", l, 0);

    // R2 R3 R4: single pulse, all offsets x widths
    foreach (offs[i]) foreach (wids[j]) begin
      run_train(offs[i], wids[j], 20, 1, 26, f, l, r);
      chk($sformatf("R3 first low off=%0.1f w=%0.1f", offs[i], wids[j]), f, 4);
      chk($sformatf("R2 R4 low length off=%0.1f w=%0.1f", offs[i], wids[j]), l, 16);
      chk("R2 single run", r, 1);
      repeat (4) @(negedge clk);
    end

    // R5 R6: trains of three pulses
    foreach (sps[i]) begin
      int sp = sps[i];
      run_train(1.0, 6.0, sp, 3, 4 + 2 * sp + 22, f, l, r);
      chk($sformatf("R5/R6 first sp=%0d", sp), f, 4);
      if (sp <= 16) begin
        chk($sformatf("R5 merged length sp=%0d", sp), l, 16 + 2 * sp);
        chk($sformatf("R5 one run sp=%0d", sp), r, 1);
      end else begin
        chk($sformatf("R6 total low sp=%0d", sp), l, 48);
        chk($sformatf("R6 runs sp=%0d", sp), r, 3);
      end
      repeat (4) @(negedge clk);
    end

    // R7: power-down during a stretch
    @(posedge clk);
    #1.0 ir_rx_n = 1'b0;
    #3.0 ir_rx_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 stretch active before pwr_dn", rx_out, 0);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk("R7 high after pwr_dn", rx_out, 1);
    #1.0 ir_rx_n = 1'b0;
    #3.0 ir_rx_n = 1'b1;
    count_lows(25, l);
    chk("R7 pulse ignored in pwr_dn", l, 0);
    pwr_dn = 1'b0;
    count_lows(25, l);
    chk("R7 no stale low after release", l, 0);
    run_train(2.0, 3.0, 20, 1, 26, f, l, r);
    chk("R7 decode resumes first", f, 4);
    chk("R7 decode resumes length", l, 16);

    // R1: reset in the middle of a stretch
    @(posedge clk);
    #1.0 ir_rx_n = 1'b0;
    #3.0 ir_rx_n = 1'b1;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset aborts stretch", rx_out, 1);
    rst_n = 1'b1;
    count_lows(20, l);
    chk("R1 idle after mid reset", l, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule